// File: doc/BRIEF.md
# Fast-Attack Receive Gain Controller

This block drives the receive gain index for bursty signals that open with a preamble. After the enable rises it waits for the receive path to settle. It then steps the gain down quickly while peak overload flags arrive. Once the input has been quiet long enough, it corrects the gain so that a decimated average power word moves toward a programmable lock level. It verifies that setting and then locks. An optional low-power branch raises the gain in small steps when the signal is weak. While the controller is locked, a sustained drop in power or any overload releases the lock and restarts acquisition. A hold input freezes the gain and the state, so a system can keep the preamble gain fixed for the payload.

The machine has seven states, and `state_code` reports the current one:
- WAIT (0): attack delay.
- ACQ (1): overload-driven reduction.
- MEAS (2): settle, then power correction.
- BOOST (3): low-power increment.
- VERIFY (4): post-correction check.
- RECOVER (5): overload seen while verifying.
- LOCK (6): gain locked.

The transitions are:
- WAIT→ACQ when the delay expires.
- ACQ→ACQ on an overload.
- ACQ→MEAS after a quiet window.
- MEAS→VERIFY after correction.
- MEAS→BOOST on low power.
- BOOST→MEAS after one increment.
- VERIFY→LOCK after a clean measurement.
- VERIFY→BOOST on low power.
- VERIFY→RECOVER on an overload.
- RECOVER→MEAS after a quiet window.
- MEAS, BOOST or LOCK → ACQ on an overload.
- LOCK→ACQ when energy is lost.
- any state → WAIT when the enable falls.

Top module: `agc_fast_ctrl`

## Requirements
- R1: Reset gives state_code 0, locked 0 and gain_idx 0. Any cycle with enable low moves the machine to WAIT (0), clears its counters and loads gain_idx with cfg_gain_max.
- R2: In WAIT the gain follows cfg_gain_max and overload flags are ignored. The machine moves to ACQ (1) on the (cfg_attack_dly+1)-th enabled cycle spent in WAIT.
- R3: In any active state (1–6), an overload lowers gain_idx by one step. The step is chosen by priority: cfg_dec_lim when ovl_lim_large is set, else cfg_dec_adc_large when ovl_adc_large is set, else cfg_dec_adc_small.
- R4: ACQ moves to MEAS (2) after max(1, cfg_energy_cnt) consecutive cycles without any overload. Each overload restarts this count.
- R5: MEAS lasts max(0, cfg_settle_dly − cfg_energy_cnt) + 16·(cfg_meas_len+1) cycles. It then adds min(cfg_lock_level − pwr_avg, cfg_max_incr) to the gain, where the difference is signed and may be negative, and moves to VERIFY (4).
- R6: An overload in ACQ, MEAS, BOOST or LOCK moves the machine to ACQ. An overload in VERIFY or RECOVER moves it to RECOVER (5).
- R7: VERIFY lasts 16·(cfg_meas_len+1) cycles and then moves to LOCK (6). RECOVER returns to MEAS after the same quiet window that R4 defines.
- R8: With cfg_incr_en set, a measurement that ends in MEAS or VERIFY with pwr_avg < cfg_low_thr moves the machine to BOOST (3). BOOST adds cfg_incr_step after max(1, cfg_incr_time) cycles and returns to MEAS. With cfg_incr_en clear, the machine never enters BOOST.
- R9: LOCK moves to ACQ after max(1, cfg_exit_cnt) consecutive cycles with pwr_avg < cfg_strong_thr. One cycle at or above that threshold restarts the count.
- R10: Every gain change saturates to [cfg_gain_min, cfg_gain_max] and never wraps.
- R11: While enable and hold are both high, gain_idx, the state and all counters keep their values.
- R12: locked is high exactly when state_code is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receive enable; low returns to WAIT |
| hold | input | 1 | Freeze gain and state |
| ovl_lim_large | input | 1 | Large limiter overload flag |
| ovl_adc_large | input | 1 | Large converter overload flag |
| ovl_adc_small | input | 1 | Small converter overload flag |
| pwr_avg | input | 8 | Decimated average power, larger is stronger |
| cfg_attack_dly | input | 16 | Attack delay in cycles |
| cfg_energy_cnt | input | 8 | Quiet window length |
| cfg_settle_dly | input | 8 | Settling delay |
| cfg_meas_len | input | 4 | Measurement length code, 16·(n+1) cycles |
| cfg_lock_level | input | 8 | Target power |
| cfg_max_incr | input | 6 | Cap on gain increase in MEAS |
| cfg_dec_lim | input | 4 | Step for a limiter overload |
| cfg_dec_adc_large | input | 4 | Step for a large converter overload |
| cfg_dec_adc_small | input | 4 | Step for a small converter overload |
| cfg_incr_en | input | 1 | Enable the low-power branch |
| cfg_low_thr | input | 8 | Low-power threshold |
| cfg_incr_step | input | 3 | Gain rise per BOOST period |
| cfg_incr_time | input | 8 | BOOST period in cycles |
| cfg_strong_thr | input | 8 | Energy threshold in LOCK |
| cfg_exit_cnt | input | 8 | Low-energy cycles that release the lock |
| cfg_gain_min | input | 7 | Lowest gain index |
| cfg_gain_max | input | 7 | Highest gain index |
| gain_idx | output | 7 | Current gain index |
| state_code | output | 3 | Current state code |
| locked | output | 1 | High in LOCK |

## Verification
The assertions assume that every configuration input stays stable while enable is high, and that cfg_gain_min is not above cfg_gain_max. The stimulus therefore changes settings only while enable is low. Overload flags and the power word are driven on the falling edge, so the controller sees them as clean synchronous inputs. Several sequences exercise the corner cases: an overload while waiting, overloads of mixed types arriving together, a hold of forty cycles in the middle of a measurement, a lock count broken by one strong sample, and corrections that reach both gain limits.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [2:0] {
        AGC_WAIT    = 3'd0,
        AGC_ACQ     = 3'd1,
        AGC_MEAS    = 3'd2,
        AGC_BOOST   = 3'd3,
        AGC_VERIFY  = 3'd4,
        AGC_RECOVER = 3'd5,
        AGC_LOCK    = 3'd6
    } agc_state_e;

    typedef enum logic [1:0] {
        GAIN_KEEP,
        GAIN_STEP,
        GAIN_LOAD_MAX
    } gain_op_e;
endpackage

// File: rtl/agc_ovl_pick.sv
module agc_ovl_pick #(
    parameter int STEP_W = 4
) (
    input  logic              lim_large,
    input  logic              adc_large,
    input  logic              adc_small,
    input  logic [STEP_W-1:0] dec_lim,
    input  logic [STEP_W-1:0] dec_adc_large,
    input  logic [STEP_W-1:0] dec_adc_small,
    output logic              hit,
    output logic [STEP_W-1:0] dec
);
    always_comb begin
        hit = lim_large | adc_large | adc_small;
        if (lim_large)      dec = dec_lim;
        else if (adc_large) dec = dec_adc_large;
        else if (adc_small) dec = dec_adc_small;
        else                dec = '0;
    end
endmodule

// File: rtl/agc_gain_clamp.sv
module agc_gain_clamp #(
    parameter int GAIN_W = 7,
    parameter int DW     = 10
) (
    input  logic [GAIN_W-1:0]    cur,
    input  logic signed [DW-1:0] delta,
    input  logic [GAIN_W-1:0]    lo,
    input  logic [GAIN_W-1:0]    hi,
    output logic [GAIN_W-1:0]    nxt
);
    localparam int SW = DW + 1;
    logic signed [SW-1:0] sum;

    always_comb begin
        sum = $signed(SW'(cur)) + SW'(delta);
        if (sum < $signed(SW'(lo)))      nxt = lo;
        else if (sum > $signed(SW'(hi))) nxt = hi;
        else                             nxt = GAIN_W'(sum);
    end
endmodule

// File: rtl/agc_fast_ctrl.sv
module agc_fast_ctrl
    import agc_pkg::*;
#(
    parameter int GAIN_W = 7,
    parameter int PWR_W  = 8,
    parameter int CNT_W  = 16,
    parameter int DLY_W  = 16,
    parameter int WIN_W  = 8,
    parameter int MEAS_W = 4,
    parameter int STEP_W = 4,
    parameter int INC_W  = 3,
    parameter int MAXI_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hold,
    input  logic              ovl_lim_large,
    input  logic              ovl_adc_large,
    input  logic              ovl_adc_small,
    input  logic [PWR_W-1:0]  pwr_avg,
    input  logic [DLY_W-1:0]  cfg_attack_dly,
    input  logic [WIN_W-1:0]  cfg_energy_cnt,
    input  logic [WIN_W-1:0]  cfg_settle_dly,
    input  logic [MEAS_W-1:0] cfg_meas_len,
    input  logic [PWR_W-1:0]  cfg_lock_level,
    input  logic [MAXI_W-1:0] cfg_max_incr,
    input  logic [STEP_W-1:0] cfg_dec_lim,
    input  logic [STEP_W-1:0] cfg_dec_adc_large,
    input  logic [STEP_W-1:0] cfg_dec_adc_small,
    input  logic              cfg_incr_en,
    input  logic [PWR_W-1:0]  cfg_low_thr,
    input  logic [INC_W-1:0]  cfg_incr_step,
    input  logic [WIN_W-1:0]  cfg_incr_time,
    input  logic [PWR_W-1:0]  cfg_strong_thr,
    input  logic [WIN_W-1:0]  cfg_exit_cnt,
    input  logic [GAIN_W-1:0] cfg_gain_min,
    input  logic [GAIN_W-1:0] cfg_gain_max,
    output logic [GAIN_W-1:0] gain_idx,
    output logic [2:0]        state_code,
    output logic              locked
);
    localparam int DW = ((GAIN_W > PWR_W) ? GAIN_W : PWR_W) + 2;

    agc_state_e           state_q, nxt_state;
    gain_op_e             gain_op;
    logic [CNT_W-1:0]     cnt_q, nxt_cnt, cnt_inc;
    logic [CNT_W-1:0]     quiet_lim, meas_len, settle_extra, meas_wait, incr_lim, exit_lim;
    logic [GAIN_W-1:0]    gain_q, gain_clamped;
    logic signed [DW-1:0] delta, pdiff, corr;
    logic                 ovl_hit, low_pwr;
    logic [STEP_W-1:0]    ovl_dec;

    agc_ovl_pick #(.STEP_W(STEP_W)) u_pick (
        .lim_large     (ovl_lim_large),
        .adc_large     (ovl_adc_large),
        .adc_small     (ovl_adc_small),
        .dec_lim       (cfg_dec_lim),
        .dec_adc_large (cfg_dec_adc_large),
        .dec_adc_small (cfg_dec_adc_small),
        .hit           (ovl_hit),
        .dec           (ovl_dec)
    );

    agc_gain_clamp #(.GAIN_W(GAIN_W), .DW(DW)) u_clamp (
        .cur   (gain_q),
        .delta (delta),
        .lo    (cfg_gain_min),
        .hi    (cfg_gain_max),
        .nxt   (gain_clamped)
    );

    // Window lengths derived from configuration
    always_comb begin
        cnt_inc      = cnt_q + CNT_W'(1);
        quiet_lim    = (cfg_energy_cnt == '0) ? CNT_W'(1) : CNT_W'(cfg_energy_cnt);
        incr_lim     = (cfg_incr_time == '0) ? CNT_W'(1) : CNT_W'(cfg_incr_time);
        exit_lim     = (cfg_exit_cnt == '0) ? CNT_W'(1) : CNT_W'(cfg_exit_cnt);
        meas_len     = (CNT_W'(cfg_meas_len) + CNT_W'(1)) << 4;
        settle_extra = (cfg_settle_dly > cfg_energy_cnt) ?
                       CNT_W'(cfg_settle_dly - cfg_energy_cnt) : '0;
        meas_wait    = settle_extra + meas_len;
        low_pwr      = cfg_incr_en && (pwr_avg < cfg_low_thr);
        pdiff        = $signed(DW'(cfg_lock_level)) - $signed(DW'(pwr_avg));
        corr         = (pdiff > $signed(DW'(cfg_max_incr))) ? $signed(DW'(cfg_max_incr)) : pdiff;
    end

    // Next-state and gain operation
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = cnt_q;
        gain_op   = GAIN_KEEP;
        delta     = '0;
        if (!enable) begin
            nxt_state = AGC_WAIT;
            nxt_cnt   = '0;
            gain_op   = GAIN_LOAD_MAX;
        end else if (hold) begin
            nxt_state = state_q;
        end else if (ovl_hit && state_q != AGC_WAIT) begin
            gain_op   = GAIN_STEP;
            delta     = -$signed(DW'(ovl_dec));
            nxt_cnt   = '0;
            nxt_state = (state_q == AGC_VERIFY || state_q == AGC_RECOVER) ? AGC_RECOVER : AGC_ACQ;
        end else begin
            unique case (state_q)
                AGC_WAIT: begin
                    gain_op = GAIN_LOAD_MAX;
                    if (cnt_q == CNT_W'(cfg_attack_dly)) begin
                        nxt_state = AGC_ACQ;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                AGC_ACQ, AGC_RECOVER: begin
                    if (cnt_inc >= quiet_lim) begin
                        nxt_state = AGC_MEAS;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                AGC_MEAS: begin
                    if (cnt_inc >= meas_wait) begin
                        nxt_cnt = '0;
                        if (low_pwr) begin
                            nxt_state = AGC_BOOST;
                        end else begin
                            nxt_state = AGC_VERIFY;
                            gain_op   = GAIN_STEP;
                            delta     = corr;
                        end
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                AGC_BOOST: begin
                    if (cnt_inc >= incr_lim) begin
                        nxt_state = AGC_MEAS;
                        nxt_cnt   = '0;
                        gain_op   = GAIN_STEP;
                        delta     = $signed(DW'(cfg_incr_step));
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                AGC_VERIFY: begin
                    if (cnt_inc >= meas_len) begin
                        nxt_cnt   = '0;
                        nxt_state = low_pwr ? AGC_BOOST : AGC_LOCK;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                AGC_LOCK: begin
                    if (pwr_avg < cfg_strong_thr) begin
                        if (cnt_inc >= exit_lim) begin
                            nxt_state = AGC_ACQ;
                            nxt_cnt   = '0;
                        end else begin
                            nxt_cnt = cnt_inc;
                        end
                    end else begin
                        nxt_cnt = '0;
                    end
                end
                default: begin
                    nxt_state = AGC_WAIT;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AGC_WAIT;
            cnt_q   <= '0;
            gain_q  <= '0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
            unique case (gain_op)
                GAIN_STEP:     gain_q <= gain_clamped;
                GAIN_LOAD_MAX: gain_q <= cfg_gain_max;
                default:       gain_q <= gain_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        gain_idx   = gain_q;
        state_code = state_q;
        locked     = (state_q == AGC_LOCK);
    end
endmodule

// File: rtl/agc_fast_ctrl_chk.sv
module agc_fast_ctrl_chk #(
    parameter int GAIN_W = 7,
    parameter int PWR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              hold,
    input logic              ovl_lim_large,
    input logic              ovl_adc_large,
    input logic              ovl_adc_small,
    input logic [PWR_W-1:0]  pwr_avg,
    input logic [PWR_W-1:0]  cfg_strong_thr,
    input logic              cfg_incr_en,
    input logic [GAIN_W-1:0] cfg_gain_min,
    input logic [GAIN_W-1:0] cfg_gain_max,
    input logic [GAIN_W-1:0] gain_idx,
    input logic [2:0]        state_code,
    input logic              locked
);
    logic any_ovl;
    assign any_ovl = ovl_lim_large | ovl_adc_large | ovl_adc_small;

    assert_disable_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_code == 3'd0 && !locked));

    assert_wait_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_code == 3'd0) |=> (state_code == 3'd0 || state_code == 3'd1));

    assert_ovl_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !hold && state_code != 3'd0 && any_ovl) |=> (gain_idx <= $past(gain_idx)));

    assert_verify_ovl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !hold && state_code == 3'd4 && any_ovl) |=> (state_code == 3'd5));

    assert_no_boost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_incr_en && state_code != 3'd3) |=> (state_code != 3'd3));

    assert_lock_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !hold && locked && !any_ovl && pwr_avg >= cfg_strong_thr) |=> locked);

    assert_gain_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 3'd0) |-> (gain_idx >= cfg_gain_min && gain_idx <= cfg_gain_max));

    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hold) |=> (gain_idx == $past(gain_idx) && state_code == $past(state_code)));
endmodule

bind agc_fast_ctrl agc_fast_ctrl_chk #(.GAIN_W(GAIN_W), .PWR_W(PWR_W)) u_chk (.*);

// File: tb/agc_fast_ctrl_test.sv
module agc_fast_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, hold = 1'b0;
    logic ovl_lim_large = 1'b0, ovl_adc_large = 1'b0, ovl_adc_small = 1'b0;
    logic [7:0]  pwr_avg = 8'd90;
    logic [15:0] cfg_attack_dly = 16'd3;
    logic [7:0]  cfg_energy_cnt = 8'd4, cfg_settle_dly = 8'd6;
    logic [3:0]  cfg_meas_len = 4'd0;
    logic [7:0]  cfg_lock_level = 8'd100;
    logic [5:0]  cfg_max_incr = 6'd10;
    logic [3:0]  cfg_dec_lim = 4'd8, cfg_dec_adc_large = 4'd4, cfg_dec_adc_small = 4'd2;
    logic        cfg_incr_en = 1'b0;
    logic [7:0]  cfg_low_thr = 8'd20;
    logic [2:0]  cfg_incr_step = 3'd5;
    logic [7:0]  cfg_incr_time = 8'd3, cfg_strong_thr = 8'd50, cfg_exit_cnt = 8'd5;
    logic [6:0]  cfg_gain_min = 7'd10, cfg_gain_max = 7'd70;
    logic [6:0]  gain_idx;
    logic [2:0]  state_code;
    logic        locked;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    agc_fast_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced on every rising edge
    int m_st = 0, m_gain = 0, m_cnt = 0;

    function automatic int clampg(int v);
        if (v < int'(cfg_gain_min)) return int'(cfg_gain_min);
        if (v > int'(cfg_gain_max)) return int'(cfg_gain_max);
        return v;
    endfunction

    function automatic int atleast1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        int q, dec, mlen, wait_len, diff;
        bit ovl, low;
        ovl  = ovl_lim_large || ovl_adc_large || ovl_adc_small;
        dec  = ovl_lim_large ? int'(cfg_dec_lim) : ovl_adc_large ? int'(cfg_dec_adc_large) :
               ovl_adc_small ? int'(cfg_dec_adc_small) : 0;
        mlen = 16 * (int'(cfg_meas_len) + 1);
        wait_len = ((cfg_settle_dly > cfg_energy_cnt) ? int'(cfg_settle_dly) - int'(cfg_energy_cnt) : 0) + mlen;
        low  = cfg_incr_en && (pwr_avg < cfg_low_thr);
        q    = m_cnt + 1;
        if (!rst_n) begin
            m_st = 0; m_gain = 0; m_cnt = 0;
        end else if (!enable) begin
            m_st = 0; m_gain = int'(cfg_gain_max); m_cnt = 0;
        end else if (hold) begin
            m_st = m_st;
        end else if (m_st == 0) begin
            m_gain = int'(cfg_gain_max);
            if (m_cnt == int'(cfg_attack_dly)) begin m_st = 1; m_cnt = 0; end
            else m_cnt = q;
        end else if (ovl) begin
            m_gain = clampg(m_gain - dec);
            m_st = (m_st == 4 || m_st == 5) ? 5 : 1;
            m_cnt = 0;
        end else if (m_st == 1 || m_st == 5) begin
            if (q >= atleast1(int'(cfg_energy_cnt))) begin m_st = 2; m_cnt = 0; end else m_cnt = q;
        end else if (m_st == 2) begin
            if (q >= wait_len) begin
                m_cnt = 0;
                if (low) m_st = 3;
                else begin
                    diff = int'(cfg_lock_level) - int'(pwr_avg);
                    if (diff > int'(cfg_max_incr)) diff = int'(cfg_max_incr);
                    m_gain = clampg(m_gain + diff);
                    m_st = 4;
                end
            end else m_cnt = q;
        end else if (m_st == 3) begin
            if (q >= atleast1(int'(cfg_incr_time))) begin
                m_gain = clampg(m_gain + int'(cfg_incr_step)); m_st = 2; m_cnt = 0;
            end else m_cnt = q;
        end else if (m_st == 4) begin
            if (q >= mlen) begin m_cnt = 0; m_st = low ? 3 : 6; end else m_cnt = q;
        end else if (m_st == 6) begin
            if (pwr_avg < cfg_strong_thr) begin
                if (q >= atleast1(int'(cfg_exit_cnt))) begin m_st = 1; m_cnt = 0; end else m_cnt = q;
            end else m_cnt = 0;
        end
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R12 locked flag included)
    always @(negedge clk) begin
        if (!done) begin
            check({cur_req, " state"}, int'(state_code), m_st);
            check({cur_req, " gain"}, int'(gain_idx), m_gain);
            check("R12 locked", int'(locked), int'(m_st == 6));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_ovl();
        ovl_lim_large = 1'b0; ovl_adc_large = 1'b0; ovl_adc_small = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1 reset state", int'(state_code), 0);
        check("R1 reset gain", int'(gain_idx), 0);
        check("R1 reset locked", int'(locked), 0);
        rst_n = 1'b1;
        step(2);
        check("R1 disabled gain", int'(gain_idx), 70);
        // R2: attack delay, overloads ignored
        cur_req = "R2";
        enable = 1'b1; ovl_lim_large = 1'b1;
        step(3);
        check("R2 still waiting", int'(state_code), 0);
        check("R2 ovl ignored", int'(gain_idx), 70);
        clr_ovl();
        step(1);
        check("R2 enter ACQ", int'(state_code), 1);
        // R3: priority of decrements
        cur_req = "R3";
        ovl_lim_large = 1'b1; step(1); check("R3 limiter step", int'(gain_idx), 62);
        clr_ovl(); ovl_adc_large = 1'b1; step(1); check("R3 large adc step", int'(gain_idx), 58);
        clr_ovl(); ovl_adc_small = 1'b1; step(1); check("R3 small adc step", int'(gain_idx), 56);
        ovl_lim_large = 1'b1; ovl_adc_large = 1'b1; step(1); check("R3 combined picks limiter", int'(gain_idx), 48);
        clr_ovl();
        // R4: quiet window
        cur_req = "R4";
        step(3); check("R4 not yet", int'(state_code), 1);
        step(1); check("R4 to MEAS", int'(state_code), 2);
        // R5: settle + measure, capped correction
        cur_req = "R5";
        step(17); check("R5 still measuring", int'(state_code), 2);
        step(1); check("R5 to VERIFY", int'(state_code), 4);
        check("R5 capped gain", int'(gain_idx), 58);
        // R7: verify then lock
        cur_req = "R7";
        step(15); check("R7 verifying", int'(state_code), 4);
        step(1); check("R7 locked state", int'(state_code), 6);
        check("R12 locked out", int'(locked), 1);
        // R9: energy lost with a broken run
        cur_req = "R9";
        pwr_avg = 8'd40; step(3);
        pwr_avg = 8'd60; step(1);
        pwr_avg = 8'd40; step(4);
        check("R9 count restarted", int'(state_code), 6);
        step(1); check("R9 unlock", int'(state_code), 1);
        check("R9 gain kept", int'(gain_idx), 58);
        // R6: overload in MEAS returns to ACQ
        cur_req = "R6";
        step(4); check("R6 in MEAS", int'(state_code), 2);
        step(5); ovl_adc_small = 1'b1; step(1);
        check("R6 MEAS ovl to ACQ", int'(state_code), 1);
        check("R6 MEAS ovl gain", int'(gain_idx), 56);
        clr_ovl(); pwr_avg = 8'd95;
        step(4); check("R6 back in MEAS", int'(state_code), 2);
        // R11: hold freezes
        cur_req = "R11";
        hold = 1'b1; step(40);
        check("R11 state held", int'(state_code), 2);
        check("R11 gain held", int'(gain_idx), 56);
        hold = 1'b0;
        cur_req = "R5";
        step(18); check("R5 resume after hold", int'(state_code), 4);
        check("R5 small correction", int'(gain_idx), 61);
        cur_req = "R6";
        step(5); ovl_lim_large = 1'b1; step(1);
        check("R6 VERIFY ovl to RECOVER", int'(state_code), 5);
        check("R6 RECOVER gain", int'(gain_idx), 53);
        clr_ovl();
        cur_req = "R7";
        step(4); check("R7 RECOVER to MEAS", int'(state_code), 2);
        // R1: disable
        cur_req = "R1";
        enable = 1'b0; step(1);
        check("R1 disable state", int'(state_code), 0);
        check("R1 disable gain", int'(gain_idx), 70);
        // R10: floor saturation
        cur_req = "R10";
        enable = 1'b1; step(4);
        ovl_lim_large = 1'b1; step(10);
        check("R10 floor", int'(gain_idx), 10);
        clr_ovl();
        // R10: ceiling saturation, R8 branch disabled
        enable = 1'b0; cfg_max_incr = 6'd63; step(1);
        enable = 1'b1; step(4);
        ovl_adc_small = 1'b1; step(1); clr_ovl();
        check("R10 before ceiling", int'(gain_idx), 68);
        pwr_avg = 8'd0; step(4);
        step(18);
        check("R8 disabled no BOOST", int'(state_code), 4);
        check("R10 ceiling", int'(gain_idx), 70);
        // R8: low-power branch
        cur_req = "R8";
        enable = 1'b0; cfg_incr_en = 1'b1; step(1);
        enable = 1'b1; step(4);
        ovl_lim_large = 1'b1; step(3); clr_ovl();
        check("R8 reduced", int'(gain_idx), 46);
        step(4); pwr_avg = 8'd10;
        step(18); check("R8 MEAS to BOOST", int'(state_code), 3);
        step(3); check("R8 BOOST to MEAS", int'(state_code), 2);
        check("R8 boosted gain", int'(gain_idx), 51);
        pwr_avg = 8'd30;
        step(18); check("R8 normal correction", int'(state_code), 4);
        check("R10 clamp after boost", int'(gain_idx), 70);
        step(15); pwr_avg = 8'd10; step(1);
        check("R8 VERIFY to BOOST", int'(state_code), 3);
        step(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule